// File: doc/BRIEF.md
# Windowed Bit-Stream Pulse Counter

This block turns the one-bit output of a sigma-delta style modulator into one number for each measurement window. An internal window sequencer produces a periodic gate signal with a programmable high time and period. A saturating counter adds one in every enabled clock cycle in which both the gate and the incoming bit are high. The count therefore measures how long the stream was high inside the window. A denser stream, such as one from a sensor with more capacitance, gives a larger number.

The gate falls at the end of each window. In that same clock edge the running count is written to a result register, the counter returns to zero, and an interrupt flag is set. The count includes the last cycle of the window, because the result is taken from the counter's next value and not from its stored value. The flag stays set until the consumer acknowledges it. If a second result arrives before the acknowledge, an overrun flag is set. The clock enable pauses the whole block, so the window timing and the count can run at a divided rate from a faster system clock. The width and period settings are sampled each time a window opens.

The window sequencer has three states. OFF means no window is running. OPEN means the gate is high. GAP means the gate is low between windows. The transitions are:
- start: OFF to OPEN, when the width setting is non-zero.
- close: OPEN to GAP, after the latched width has elapsed. This is the capture point.
- reopen: GAP to OPEN, after the gap has elapsed, when the width setting is non-zero.
- stop: GAP to OFF, when the width setting is zero.

Top module: `bitstream_window_counter`

## Requirements
- R1: Once started, `win_open` is high for exactly `width_cfg` enabled cycles, then low for `period_cfg - width_cfg` enabled cycles. The low time is one enabled cycle when `width_cfg >= period_cfg`. The pattern then repeats.
- R2: While `width_cfg` is 0 no window opens: `win_open` stays low and `irq` is never set.
- R3: A window's count equals the number of clock cycles in which `clk_en`, `win_open` and `bit_in` were all high during that window, the final open cycle included.
- R4: `count_out` changes only at the clock edge where `win_open` falls. At that edge it takes the count of the window just closed, and the next window's count starts from zero.
- R5: The count saturates at 2^CNT_W − 1 (255 by default) and never wraps.
- R6: While `clk_en` is low, the window timing and the running count hold their values.
- R7: `irq` is set at every capture and stays set until `irq_ack` is seen high at a clock edge. A capture in that same edge keeps it set.
- R8: A capture while `irq` is set and `irq_ack` is low sets `overrun`. `irq_ack` clears it.
- R9: After reset, `count_out`, `irq`, `overrun` and `win_open` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Advances the sequencer and the counter when high |
| bit_in | input | 1 | Modulator bit stream |
| width_cfg | input | PER_W | Window high time in enabled cycles; 0 stops windowing |
| period_cfg | input | PER_W | Window period in enabled cycles |
| irq_ack | input | 1 | Clears `irq` and `overrun` |
| win_open | output | 1 | The window gate |
| count_out | output | CNT_W | Count of the last closed window |
| irq | output | 1 | A new result is waiting |
| overrun | output | 1 | A result was replaced before it was acknowledged |

## Verification
The sharpest boundary is the last open cycle. A design that captures the stored count instead of the next value drops that cycle, and dense streams then read one short. A window of 300 cycles with an all-ones stream pushes the counter past 255, and a counter that wraps would report 44. The bench also covers a width at or above the period, where a sequencer without a minimum gap would never close a window and so never capture. A clock-enable pattern that pauses one cycle in three catches a counter or sequencer that ignores the enable, because the window lengths and the counts then no longer match the enabled cycles. Leaving results unacknowledged tests both the flag that must hold and the overrun that must appear exactly on the second capture.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    // Window sequencer states
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_OPEN = 2'd1,
        PH_GAP  = 2'd2
    } win_state_e;

endpackage

// File: rtl/bwc_window_fsm.sv
module bwc_window_fsm
    import bwc_pkg::*;
#(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [PER_W-1:0] width_cfg,
    input  logic [PER_W-1:0] period_cfg,
    output logic             win_open,
    output logic             win_end
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    win_state_e       st_q, st_d;
    logic [PER_W-1:0] ph_q;
    logic [PER_W-1:0] w_q;
    logic [PER_W-1:0] gap_q;
    logic [PER_W-1:0] gap_new;
    logic             load;
    logic             open_last;
    logic             gap_last;

    // The gap is at least one cycle, so a high-to-low edge always occurs
    assign gap_new   = (period_cfg > width_cfg) ? (period_cfg - width_cfg) : ONE;
    assign open_last = (ph_q == (w_q - ONE));
    assign gap_last  = (ph_q == (gap_q - ONE));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            PH_OFF: begin
                if (clk_en && (width_cfg != '0)) begin
                    st_d = PH_OPEN;   // start
                    load = 1'b1;
                end
            end
            PH_OPEN: begin
                if (clk_en && open_last) begin
                    st_d = PH_GAP;    // close
                end
            end
            PH_GAP: begin
                if (clk_en && gap_last) begin
                    if (width_cfg != '0) begin
                        st_d = PH_OPEN;   // reopen
                        load = 1'b1;
                    end else begin
                        st_d = PH_OFF;    // stop
                    end
                end
            end
            default: st_d = PH_OFF;
        endcase
    end

    // State register with phase counter and the settings latched at window start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_OFF;
            ph_q  <= '0;
            w_q   <= ONE;
            gap_q <= ONE;
        end else begin
            st_q <= st_d;
            if (st_d != st_q) begin
                ph_q <= '0;
            end else if (clk_en && (st_q != PH_OFF)) begin
                ph_q <= ph_q + ONE;
            end
            if (load) begin
                w_q   <= width_cfg;
                gap_q <= gap_new;
            end
        end
    end

    // Outputs
    always_comb begin
        win_open = 1'b0;
        win_end  = 1'b0;
        unique case (st_q)
            PH_OFF:  win_open = 1'b0;
            PH_OPEN: begin
                win_open = 1'b1;
                win_end  = clk_en && open_last;
            end
            PH_GAP:  win_open = 1'b0;
            default: win_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/bwc_sat_counter.sv
module bwc_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // The next value includes the current cycle, so a capture taken from it keeps the last bit
    assign cnt_nxt = (inc && (cnt_q != CNT_MAX)) ? (cnt_q + CNT_W'(1)) : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/bwc_capture.sv
module bwc_capture #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count_out,
    output logic             irq,
    output logic             overrun
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_out <= '0;
            irq       <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (win_end) begin
                count_out <= cap_val;
            end
            if (win_end) begin
                irq <= 1'b1;
            end else if (irq_ack) begin
                irq <= 1'b0;
            end
            if (win_end && irq && !irq_ack) begin
                overrun <= 1'b1;
            end else if (irq_ack) begin
                overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bitstream_window_counter.sv
module bitstream_window_counter #(
    parameter int PER_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             bit_in,
    input  logic [PER_W-1:0] width_cfg,
    input  logic [PER_W-1:0] period_cfg,
    input  logic             irq_ack,
    output logic             win_open,
    output logic [CNT_W-1:0] count_out,
    output logic             irq,
    output logic             overrun
);

    logic             win_end;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt_nxt;

    bwc_window_fsm #(.PER_W(PER_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .width_cfg  (width_cfg),
        .period_cfg (period_cfg),
        .win_open   (win_open),
        .win_end    (win_end)
    );

    // Gated enable: stream AND window AND clock enable
    assign cnt_inc = clk_en & win_open & bit_in;

    bwc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .clear   (win_end),
        .cnt_q   (cnt_val),
        .cnt_nxt (cnt_nxt)
    );

    bwc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .cap_val   (cnt_nxt),
        .irq_ack   (irq_ack),
        .count_out (count_out),
        .irq       (irq),
        .overrun   (overrun)
    );

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             irq_ack,
    input logic             win_open,
    input logic             win_end,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] count_out,
    input logic             irq,
    input logic             overrun
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R7: a window closing always leaves the interrupt set
    p_irq_on_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(win_open) |-> irq);

    // R7: an acknowledge clears the flag unless a capture happens in the same edge
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq || $fell(win_open)));

    // R4: the result register moves only when a window closes
    p_result_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(win_open) |-> $stable(count_out));

    // R8: overrun appears only at a capture
    p_overrun_at_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $fell(win_open));

    // R6: a paused cycle does not move the window gate
    p_pause_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(win_open));

    // R5: a full counter stays full until the window ends
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == CNT_MAX && !win_end) |=> (cnt_val == CNT_MAX));

endmodule

bind bitstream_window_counter bwc_checker #(.CNT_W(CNT_W)) u_bwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .irq_ack   (irq_ack),
    .win_open  (win_open),
    .win_end   (win_end),
    .cnt_val   (cnt_val),
    .count_out (count_out),
    .irq       (irq),
    .overrun   (overrun)
);

// File: tb/bitstream_window_counter_bench.sv
module bitstream_window_counter_bench;

    localparam int CLK_P = 10;
    localparam int PER_W = 10;
    localparam int CNT_W = 8;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b1;
    logic             bit_in = 1'b0;
    logic [PER_W-1:0] width_cfg = '0;
    logic [PER_W-1:0] period_cfg = '0;
    logic             irq_ack = 1'b0;
    logic             win_open;
    logic [CNT_W-1:0] count_out;
    logic             irq;
    logic             overrun;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    bitstream_window_counter #(.PER_W(PER_W), .CNT_W(CNT_W)) u_bitstream_window_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .bit_in     (bit_in),
        .width_cfg  (width_cfg),
        .period_cfg (period_cfg),
        .irq_ack    (irq_ack),
        .win_open   (win_open),
        .count_out  (count_out),
        .irq        (irq),
        .overrun    (overrun)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int w, input int p);
        rst_n      = 1'b0;
        width_cfg  = PER_W'(w);
        period_cfg = PER_W'(p);
        bit_in     = 1'b0;
        clk_en     = 1'b1;
        irq_ack    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic bit stream_bit(input int mode, input int cyc);
        case (mode)
            0:       return 1'b1;
            1:       return 1'b0;
            2:       return cyc[0];
            default: return (cyc % 5) < 2;
        endcase
    endfunction

    function automatic bit en_bit(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        return (cyc % 3) != 2;
    endfunction

    // Runs windows and checks lengths (R1), counts (R3/R4/R5), flags (R7/R8)
    task automatic run_win(input int w, input int p, input int nwin, input int bmode,
                           input int emode, input bit do_ack, input string req);
        int seen = 0;
        int cyc = 0;
        int exp_cnt = 0;
        int hi = 0;
        int lo = 0;
        int gap = (p > w) ? (p - w) : 1;
        bit pw = 1'b0;
        bit pb = 1'b0;
        bit pe = 1'b1;
        bit closed_once = 1'b0;
        bit ack_prev = 1'b0;
        while (seen < nwin && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            irq_ack = 1'b0;
            if (pe && pw && pb && exp_cnt < SAT) exp_cnt++;
            if (pe && pw) hi++;
            if (pe && !pw && closed_once) lo++;
            if (ack_prev && !(pw && !win_open))
                chk(irq == 1'b0, "R7", "irq after ack", int'(irq), 0);
            ack_prev = 1'b0;
            if (pw && !win_open) begin
                chk(int'(count_out) == exp_cnt, req, "window count", int'(count_out), exp_cnt);
                chk(irq == 1'b1, "R7", "irq at capture", int'(irq), 1);
                chk(hi == w, "R1", "open length", hi, w);
                if (do_ack) begin
                    chk(overrun == 1'b0, "R8", "no overrun when acked", int'(overrun), 0);
                    irq_ack  = 1'b1;
                    ack_prev = 1'b1;
                end
                exp_cnt = 0;
                hi = 0;
                lo = 0;
                seen++;
                closed_once = 1'b1;
            end
            if (!pw && win_open && closed_once) begin
                chk(lo == gap, "R1", "gap length", lo, gap);
                lo = 0;
            end
            bit_in = stream_bit(bmode, cyc);
            clk_en = en_bit(emode, cyc);
            pw = win_open;
            pb = bit_in;
            pe = clk_en;
        end
        chk(seen == nwin, req, "windows closed", seen, nwin);
    endtask

    task automatic t_reset();
        do_reset(5, 10);
        chk(count_out == '0, "R9", "count after reset", int'(count_out), 0);
        chk(irq == 1'b0, "R9", "irq after reset", int'(irq), 0);
        chk(overrun == 1'b0, "R9", "overrun after reset", int'(overrun), 0);
        chk(win_open == 1'b0, "R9", "window after reset", int'(win_open), 0);
    endtask

    task automatic t_all_ones();
        do_reset(10, 16);
        run_win(10, 16, 3, 0, 0, 1'b1, "R3");
    endtask

    task automatic t_alternating();
        do_reset(9, 20);
        run_win(9, 20, 3, 2, 0, 1'b1, "R3");
    endtask

    task automatic t_sparse();
        do_reset(13, 17);
        run_win(13, 17, 3, 3, 0, 1'b1, "R4");
    endtask

    task automatic t_zero_stream();
        do_reset(7, 12);
        run_win(7, 12, 2, 1, 0, 1'b1, "R3");
    endtask

    task automatic t_saturate();
        do_reset(300, 310);
        run_win(300, 310, 2, 0, 0, 1'b1, "R5");
    endtask

    task automatic t_width_ge_period();
        do_reset(12, 8);
        run_win(12, 8, 3, 0, 0, 1'b1, "R1");
    endtask

    task automatic t_paused();
        do_reset(11, 19);
        run_win(11, 19, 3, 3, 1, 1'b1, "R6");
    endtask

    task automatic t_zero_width();
        bit seen_open = 1'b0;
        do_reset(0, 10);
        bit_in = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (win_open) seen_open = 1'b1;
        end
        chk(seen_open == 1'b0, "R2", "window with zero width", int'(seen_open), 0);
        chk(irq == 1'b0, "R2", "irq with zero width", int'(irq), 0);
    endtask

    task automatic t_overrun();
        do_reset(4, 8);
        run_win(4, 8, 2, 0, 0, 1'b0, "R8");
        chk(overrun == 1'b1, "R8", "overrun on second capture", int'(overrun), 1);
        chk(int'(count_out) == 4, "R8", "latest count kept", int'(count_out), 4);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R7", "irq held without ack", int'(irq), 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(irq == 1'b0, "R7", "irq cleared by ack", int'(irq), 0);
        chk(overrun == 1'b0, "R8", "overrun cleared by ack", int'(overrun), 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_ones();
        t_alternating();
        t_sparse();
        t_zero_stream();
        t_saturate();
        t_width_ge_period();
        t_paused();
        t_zero_width();
        t_overrun();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule